// File: doc/BRIEF.md
# Single-Word DMA I/O Handshake Engine

This block runs one external bus cycle of a single-word DMA transfer between a requesting I/O port and memory. When a cycle is started for a channel, the engine pulls that channel's active-low port select low and holds the address strobe low. It then works through either a memory read or a memory write. On a read, a port write strobe marks valid memory data. On a write, a port read strobe tells the port to drive its data, and the memory write-enable is held back until the port signals that the data is valid. The port's active-low request line serves as the handshake return path.

The engine checks where the request release falls in time. If the port drops its request well before the strobe would assert, the handshake is skipped and the cycle ends on memory ready alone. A watchdog counts the clocks spent waiting on the port or on memory and aborts a stalled cycle with a sticky timeout flag. Each cycle ends with a one-clock end-of-cycle pulse in which every line is released. Wait-state generation and data steering are left to neighbouring logic.

Top module: `dma_hs_engine`

## Requirements
- R1: After reset, and whenever no cycle is running, all bits of `ack_n` are 1, `strobe_n`, `ack_wr_n` and `ack_rd_n` are 1, and `mem_we`, `as_end` and `bus_to` are 0.
- R2: When `cyc_start` is sampled high while idle, `ack_n[cyc_chan]` (bit index = channel number) goes low in the next cycle, every other `ack_n` bit stays high, and `strobe_n` goes low.
- R3: On a read (`cyc_wr`=0) with handshake, `ack_wr_n` goes low in the cycle after the first clock edge that samples `rdy_n` low, and `ack_n` stays low with it.
- R4: On a read with handshake, the channel's `ack_n` rises in the cycle after the first edge that samples the channel's `req_n` high, with that edge at least one edge after `ack_wr_n` fell. `strobe_n` and `ack_wr_n` stay low for that one extra cycle, and the end pulse follows.
- R5: On a write (`cyc_wr`=1) with handshake, `ack_rd_n` goes low from the cycle after the second edge of the cycle. `mem_we` rises only in the cycle after an edge, at the second edge or later, that samples `req_n` high.
- R6: On a write, `mem_we`, `ack_n` and `ack_rd_n` stay asserted until the first edge, at least one edge after `mem_we` rose, that samples `rdy_n` low. The end pulse follows directly.
- R7: Early release. On a read, if `req_n` is sampled high both at the edge that first sees `rdy_n` low and at the edge before it, `ack_wr_n` never falls and the end pulse comes in the next cycle. On a write, if `req_n` is sampled high at the start edge and at the next edge, `ack_rd_n` never falls and `mem_we` is high from the cycle after the second edge until ready ends the cycle.
- R8: If a cycle spends 256 clock edges in its waiting states without progress, it is aborted. The end pulse appears in the next cycle together with `bus_to`=1, and `bus_to` stays 1 until the next accepted start.
- R9: At most one bit of `ack_n` is low at any time.
- R10: `cyc_start` and `cyc_chan` are ignored while a cycle runs. The serviced channel and the cycle's timing do not change.
- R11: `as_end` is a single-cycle pulse at the end of every cycle. In that cycle all `ack_n`, `strobe_n`, `ack_wr_n` and `ack_rd_n` are high and `mem_we` is low. The engine is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Start a cycle (accepted only when idle) |
| cyc_wr | input | 1 | 1 = memory write (port to memory), 0 = memory read |
| cyc_chan | input | CH_W | Channel being serviced |
| req_n | input | NUM_CH | Active-low request line per channel |
| rdy_n | input | 1 | Active-low memory ready |
| ack_n | output | NUM_CH | Active-low port select per channel |
| ack_wr_n | output | 1 | Active-low port write strobe (memory reads) |
| ack_rd_n | output | 1 | Active-low port read strobe (memory writes) |
| strobe_n | output | 1 | Active-low address strobe, low while the cycle runs |
| mem_we | output | 1 | Memory write-enable |
| as_end | output | 1 | End-of-cycle pulse |
| bus_to | output | 1 | Sticky bus timeout flag |

## Verification
On a read, the ready sample and the request release can land on the same clock edge. Whether that edge opens the handshake or takes the early-release path depends only on the request sample one edge earlier. The sweep moves the release edge and the ready edge against each other over every offset on every channel. For each cycle it computes the expected phase from the two edge numbers, so the coinciding, one-apart and two-apart cases are each judged against their own expected strobe pattern. The timeout is also driven into the cycle where a handshake wait has just begun, to check that the abort edge counts only the edges that made no progress.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_WAIT   = 3'd1,
    S_RD_HS  = 3'd2,
    S_RD_REL = 3'd3,
    S_WR_HS  = 3'd4,
    S_WR_MEM = 3'd5,
    S_DONE   = 3'd6
  } hs_state_t;

  // Request seen high now and on the previous edge: too early for a handshake.
  function automatic logic early_release(input logic prev_hi, input logic req_hi);
    return prev_hi && req_hi;
  endfunction

  // Port select held low in these states.
  function automatic logic ack_phase(input hs_state_t s);
    return (s == S_WAIT) || (s == S_RD_HS) || (s == S_WR_HS) || (s == S_WR_MEM);
  endfunction

  // Address strobe held low in these states.
  function automatic logic strobe_phase(input hs_state_t s);
    return ack_phase(s) || (s == S_RD_REL);
  endfunction

endpackage

// File: rtl/dma_hs_wdog.sv
module dma_hs_wdog #(
  parameter int TO_LIMIT = 256,
  parameter int CNT_W    = (TO_LIMIT > 1) ? $clog2(TO_LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wait_en,
  input  logic progress,
  output logic expire
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             stall;

  assign stall  = wait_en && !progress;
  assign expire = stall && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (expire)   cnt_q <= '0;
    else if (stall)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dma_hs_ackdec.sv
module dma_hs_ackdec #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              ack_on,
  input  logic [CH_W-1:0]   chan,
  output logic [NUM_CH-1:0] ack_n
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign ack_n[i] = !(ack_on && (chan == CH_W'(i)));
  end
endmodule

// File: rtl/dma_hs_fsm.sv
module dma_hs_fsm
  import dma_hs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              cyc_wr,
  input  logic [CH_W-1:0]   cyc_chan,
  input  logic [NUM_CH-1:0] req_n,
  input  logic              rdy_n,
  input  logic              expire,
  output hs_state_t         state,
  output logic [CH_W-1:0]   chan_q,
  output logic              skip_q,
  output logic              start_ev,
  output logic              wait_en,
  output logic              progress
);
  hs_state_t       nxt;
  logic            wr_q;
  logic            prev_hi;
  logic [CH_W-1:0] chan_sel;
  logic            req_hi;
  logic            early;
  logic            decide_ev;

  assign chan_sel  = (state == S_IDLE) ? cyc_chan : chan_q;
  assign req_hi    = req_n[chan_sel];
  assign early     = early_release(prev_hi, req_hi);
  assign start_ev  = (state == S_IDLE) && cyc_start;
  assign decide_ev = (state == S_WAIT) && (wr_q || !rdy_n);

  always_comb begin
    nxt      = state;
    wait_en  = 1'b0;
    progress = 1'b0;
    case (state)
      S_IDLE:   if (cyc_start) nxt = S_WAIT;
      S_WAIT: begin
        if (wr_q) begin
          nxt = early ? S_WR_MEM : S_WR_HS;
        end else begin
          wait_en  = 1'b1;
          progress = !rdy_n;
          if (!rdy_n) nxt = early ? S_DONE : S_RD_HS;
        end
      end
      S_RD_HS: begin
        wait_en  = 1'b1;
        progress = req_hi;
        if (req_hi) nxt = S_RD_REL;
      end
      S_RD_REL: nxt = S_DONE;
      S_WR_HS: begin
        wait_en  = 1'b1;
        progress = req_hi;
        if (req_hi) nxt = S_WR_MEM;
      end
      S_WR_MEM: begin
        wait_en  = 1'b1;
        progress = !rdy_n;
        if (!rdy_n) nxt = S_DONE;
      end
      S_DONE:   nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
    if (expire) nxt = S_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      chan_q  <= '0;
      wr_q    <= 1'b0;
      prev_hi <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      state   <= nxt;
      prev_hi <= req_hi;
      if (start_ev) begin
        chan_q <= cyc_chan;
        wr_q   <= cyc_wr;
        skip_q <= 1'b0;
      end else if (decide_ev) begin
        skip_q <= early;
      end
    end
  end
endmodule

// File: rtl/dma_hs_engine.sv
module dma_hs_engine
  import dma_hs_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int TO_LIMIT = 256,
  parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              cyc_wr,
  input  logic [CH_W-1:0]   cyc_chan,
  input  logic [NUM_CH-1:0] req_n,
  input  logic              rdy_n,
  output logic [NUM_CH-1:0] ack_n,
  output logic              ack_wr_n,
  output logic              ack_rd_n,
  output logic              strobe_n,
  output logic              mem_we,
  output logic              as_end,
  output logic              bus_to
);
  hs_state_t       state;
  logic [CH_W-1:0] chan_q;
  logic            skip_q;
  logic            start_ev;
  logic            wait_en;
  logic            progress;
  logic            to_fire;
  logic            idle_w;

  dma_hs_fsm #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_start(cyc_start),
    .cyc_wr   (cyc_wr),
    .cyc_chan (cyc_chan),
    .req_n    (req_n),
    .rdy_n    (rdy_n),
    .expire   (to_fire),
    .state    (state),
    .chan_q   (chan_q),
    .skip_q   (skip_q),
    .start_ev (start_ev),
    .wait_en  (wait_en),
    .progress (progress)
  );

  dma_hs_wdog #(.TO_LIMIT(TO_LIMIT)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start_ev),
    .wait_en (wait_en),
    .progress(progress),
    .expire  (to_fire)
  );

  dma_hs_ackdec #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ackdec (
    .ack_on(ack_phase(state)),
    .chan  (chan_q),
    .ack_n (ack_n)
  );

  assign idle_w   = (state == S_IDLE);
  assign strobe_n = !strobe_phase(state);
  assign ack_wr_n = !((state == S_RD_HS) || (state == S_RD_REL));
  assign ack_rd_n = !((state == S_WR_HS) || ((state == S_WR_MEM) && !skip_q));
  assign mem_we   = (state == S_WR_MEM);
  assign as_end   = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bus_to <= 1'b0;
    else if (start_ev) bus_to <= 1'b0;
    else if (to_fire)  bus_to <= 1'b1;
  end
endmodule

// File: rtl/dma_hs_engine_chk.sv
module dma_hs_engine_chk #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ack_n,
  input logic              ack_wr_n,
  input logic              ack_rd_n,
  input logic              strobe_n,
  input logic              mem_we,
  input logic              as_end,
  input logic              bus_to,
  input logic              idle_w,
  input logic              start_ev,
  input logic              to_fire,
  input logic [CH_W-1:0]   chan_q
);
  assert_ack_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ack_n) <= 1);

  assert_start_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (!strobe_n && ($countones(~ack_n) == 1)));

  assert_end_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    as_end |-> ((&ack_n) && strobe_n && ack_wr_n && ack_rd_n && !mem_we));

  assert_end_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    as_end |=> (!as_end && idle_w));

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ack_wr_n && !ack_rd_n));

  assert_write_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!strobe_n && !(&ack_n)));

  assert_akwr_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_wr_n) |-> !(&ack_n));

  assert_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    to_fire |=> (as_end && bus_to));

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_w |=> $stable(chan_q));
endmodule

bind dma_hs_engine dma_hs_engine_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ack_n   (ack_n),
  .ack_wr_n(ack_wr_n),
  .ack_rd_n(ack_rd_n),
  .strobe_n(strobe_n),
  .mem_we  (mem_we),
  .as_end  (as_end),
  .bus_to  (bus_to),
  .idle_w  (idle_w),
  .start_ev(start_ev),
  .to_fire (to_fire),
  .chan_q  (chan_q)
);

// File: tb/dma_hs_engine_tb.sv
`timescale 1ns/1ps
module dma_hs_engine_tb;
  localparam int NCH = 4;
  localparam int CHW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cyc_start = 1'b0;
  logic           cyc_wr = 1'b0;
  logic [CHW-1:0] cyc_chan = '0;
  logic [NCH-1:0] req_n = '1;
  logic           rdy_n = 1'b1;
  logic [NCH-1:0] ack_n;
  logic           ack_wr_n, ack_rd_n, strobe_n, mem_we, as_end, bus_to;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dma_hs_engine #(.NUM_CH(NCH), .TO_LIMIT(256)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_wr(cyc_wr),
    .cyc_chan(cyc_chan), .req_n(req_n), .rdy_n(rdy_n), .ack_n(ack_n),
    .ack_wr_n(ack_wr_n), .ack_rd_n(ack_rd_n), .strobe_n(strobe_n),
    .mem_we(mem_we), .as_end(as_end), .bus_to(bus_to)
  );

  // Packed observation: {ack_n, strobe_n, ack_wr_n, ack_rd_n, mem_we, as_end, bus_to}
  function automatic logic [NCH+5:0] obs();
    return {ack_n, strobe_n, ack_wr_n, ack_rd_n, mem_we, as_end, bus_to};
  endfunction

  // Phase codes: 0 idle, 1 wait, 2 read hs, 3 read release, 4 write hs,
  // 5 write mem (hs), 6 write mem (early), 7 end pulse
  function automatic logic [NCH+5:0] phase_vec(int ph, int ch, logic to);
    logic [NCH-1:0] a = '1;
    logic s = 1'b1, aw = 1'b1, ar = 1'b1, we = 1'b0, en = 1'b0;
    if (ph == 1 || ph == 2 || ph == 4 || ph == 5 || ph == 6) a[ch] = 1'b0;
    if (ph >= 1 && ph <= 6) s = 1'b0;
    if (ph == 2 || ph == 3) aw = 1'b0;
    if (ph == 4 || ph == 5) ar = 1'b0;
    if (ph == 5 || ph == 6) we = 1'b1;
    if (ph == 7) en = 1'b1;
    return {a, s, aw, ar, we, en, to};
  endfunction

  function automatic string phase_tag(int ph);
    case (ph)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R11";
    endcase
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Expected phase after edge k, given request-high edge q and ready-low edge r.
  function automatic int exp_phase(logic wr, int q, int r, int k);
    int h, m;
    if (!wr) begin
      if (q <= r - 1) begin
        if (k < r) return 1;
        if (k == r) return 7;
        return 0;
      end
      h = imax(q, r + 1);
      if (k < r) return 1;
      if (k < h) return 2;
      if (k == h) return 3;
      if (k == h + 1) return 7;
      return 0;
    end
    if (q == 0) begin
      m = imax(r, 2);
      if (k == 0) return 1;
      if (k < m) return 6;
      if (k == m) return 7;
      return 0;
    end
    h = imax(q, 2);
    m = imax(r, h + 1);
    if (k == 0) return 1;
    if (k < h) return 4;
    if (k < m) return 5;
    if (k == m) return 7;
    return 0;
  endfunction

  task automatic check(string tag, logic [NCH+5:0] got, logic [NCH+5:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check_onehot();
    n_chk++;
    if ($countones(~ack_n) > 1) begin
      n_bad++;
      $display("FAIL R9: ack_n %b expected at most one low", ack_n);
    end
  endtask

  task automatic run_cycle(logic wr, int ch, int q, int r);
    int last = 0;
    for (int k = 0; k < 40; k++) if (exp_phase(wr, q, r, k) == 7) last = k;
    for (int k = 0; k <= last + 1; k++) begin
      int ph;
      cyc_start = (k == 0) || (k == 1);
      cyc_wr    = (k == 1) ? !wr : wr;
      cyc_chan  = (k == 1) ? CHW'((ch + 1) % NCH) : CHW'(ch);
      req_n     = '0;
      req_n[ch] = (k >= q);
      rdy_n     = !(k >= r);
      @(posedge clk);
      @(negedge clk);
      ph = exp_phase(wr, q, r, k);
      check(phase_tag(ph), obs(), phase_vec(ph, ch, 1'b0));
      check_onehot();
      if (k == 1) check("R10", obs(), phase_vec(ph, ch, 1'b0));
    end
    cyc_start = 1'b0;
    req_n = '1;
    rdy_n = 1'b1;
  endtask

  // Timeout: request held low throughout; ready low from edge r (r<0: never).
  task automatic run_timeout(logic wr, int ch, int r, int exp_edge);
    int seen = -1;
    for (int k = 0; k < 300 && seen < 0; k++) begin
      cyc_start = (k == 0);
      cyc_wr    = wr;
      cyc_chan  = CHW'(ch);
      req_n     = '1;
      req_n[ch] = 1'b0;
      rdy_n     = !(r >= 0 && k >= r);
      @(posedge clk);
      @(negedge clk);
      if (as_end) begin
        seen = k;
        check("R8", {as_end, bus_to}, 2'b11);
      end
    end
    n_chk++;
    if (seen != exp_edge) begin
      n_bad++;
      $display("FAIL R8: abort edge %0d expected %0d", seen, exp_edge);
    end
    cyc_start = 1'b0;
    req_n = '1;
    rdy_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", obs(), phase_vec(0, ch, 1'b1));
    // Next accepted start clears the flag.
    cyc_start = 1'b1;
    cyc_wr = 1'b0;
    cyc_chan = CHW'(ch);
    req_n[ch] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cyc_start = 1'b0;
    check("R8", obs(), phase_vec(1, ch, 1'b0));
    rdy_n = 1'b0;
    req_n[ch] = 1'b1;
    repeat (4) @(negedge clk);
    rdy_n = 1'b1;
    req_n = '1;
    @(negedge clk);
    check("R1", obs(), phase_vec(0, ch, 1'b0));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R1", obs(), phase_vec(0, 0, 1'b0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", obs(), phase_vec(0, 0, 1'b0));

    for (int ch = 0; ch < NCH; ch++) begin
      for (int q = 0; q <= 5; q++)
        for (int r = 1; r <= 4; r++) run_cycle(1'b0, ch, q, r);
      for (int q = 0; q <= 4; q++)
        for (int r = 1; r <= 6; r++) run_cycle(1'b1, ch, q, r);
    end

    run_timeout(1'b0, 2, -1, 256);
    run_timeout(1'b0, 1, 1, 257);
    run_timeout(1'b1, 3, -1, 257);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule